// File: doc/BRIEF.md
# Floating-Point Charge Code Encoder

This block turns a linear, unsigned charge sample into a compact floating-point code. The sample is counted in least-count units. The code has two parts: a 2-bit range exponent and a 6-bit mantissa with unequal bin widths. The four ranges are spaced by a factor of 8 in gain. Inside a range, the mantissa covers 192 range-local units with 64 bins. Those bins fall into four segments whose widths are 1, 2, 4 and 8 local units. The result is roughly constant relative precision over a span of about 17 bits.

The encoder is fully pipelined. It takes a new sample on every clock and delivers one code per clock three cycles later, so it never stalls. A valid flag travels with the data. Next to the code it gives the centre of the chosen bin in linear input units. A consumer can use that value to decode the code, or to check the encoding against the original sample.

Top module: `fq_encoder`

## Requirements
- R1: A sample presented with `in_valid` high in clock cycle t appears on the outputs in cycle t+3 with `out_valid` high. `out_valid` is low in cycle t+3 whenever `in_valid` was low in cycle t.
- R2: The range `out_range` is the smallest r in 0..3 for which floor(Q / 8^r) < 192.
- R3: A sample Q >= 98304 (192·512) saturates to `out_range` = 3 and `out_mant` = 63.
- R4: For a local value L = floor(Q / 8^r), the mantissa is as follows. For L < 16 it is L. For 16 <= L < 64 it is 16 + (L-16)/2. For 64 <= L < 128 it is 40 + (L-64)/4. For 128 <= L < 192 it is 56 + (L-128)/8. All divisions are integer divisions.
- R5: `out_recon` is 8^r·lo + floor(8^r·w / 2). Here lo is the lower local edge of the output bin and w is its local width (1, 2, 4 or 8, by segment).
- R6: For an unsaturated sample, |Q − out_recon| is at most half the bin width in input units (w·8^r / 2).
- R7: A synchronous active-high reset clears every pipeline stage. In the cycle after a reset edge, `out_valid`, `out_range`, `out_mant` and `out_recon` are all zero. No sample accepted before the reset ever emerges.
- R8: For codes in ranges 1 to 3, the local bin width w and lower edge lo satisfy 12·w <= lo <= 32·w. This bounds the relative bin width to within a factor of 2.7.
- R9: Samples presented on consecutive clocks each produce their own code on consecutive clocks, with no lost or repeated cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_q` in this cycle |
| in_q | input | IN_W (17) | Linear charge sample in least-count units |
| out_valid | output | 1 | Qualifies the code outputs |
| out_range | output | 2 | Range exponent |
| out_mant | output | 6 | Non-uniform mantissa |
| out_recon | output | IN_W (17) | Bin centre in linear input units |

## Verification
The checker assumes a fixed input width of 17 bits, with a linear sample that needs no sign. It pairs each output with the sample taken three edges earlier, but only after three clean cycles have passed since reset. Until then the pipeline may hold data that was cleared rather than accepted. The directed stimulus keeps inputs within 0 to 131071 and deasserts `in_valid` during reset. It then waits out the three-cycle window before it relies on any paired output.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int RNG_W     = 2;
    localparam int N_RNG     = 1 << RNG_W;
    localparam int RNG_SHIFT = 3;
    localparam int MANT_W    = 6;
    localparam int LOC_W     = 8;
    localparam int LOC_SPAN  = 192;
    localparam int SEG_W     = 2;
    localparam int N_SEG     = 1 << SEG_W;

    typedef logic [RNG_W-1:0]  rng_t;
    typedef logic [MANT_W-1:0] mant_t;
    typedef logic [LOC_W-1:0]  loc_t;
    typedef logic [SEG_W-1:0]  seg_t;

    // Stage 1 result: chosen range and range-local value
    typedef struct packed {
        logic vld;
        logic sat;
        rng_t rng;
        loc_t loc;
    } sel_t;

    // Stage 2 result: segment and mantissa
    typedef struct packed {
        logic  vld;
        rng_t  rng;
        seg_t  seg;
        mant_t mant;
    } qnt_t;

    // Lowest local value covered by a segment
    function automatic loc_t seg_lo(seg_t s);
        case (s)
            2'd0:    return loc_t'(0);
            2'd1:    return loc_t'(16);
            2'd2:    return loc_t'(64);
            default: return loc_t'(128);
        endcase
    endfunction

    // First mantissa code of a segment
    function automatic mant_t seg_base(seg_t s);
        case (s)
            2'd0:    return mant_t'(0);
            2'd1:    return mant_t'(16);
            2'd2:    return mant_t'(40);
            default: return mant_t'(56);
        endcase
    endfunction

endpackage

// File: rtl/fq_range_sel.sv
module fq_range_sel
    import fq_pkg::*;
#(
    parameter int IN_W = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_q,
    output sel_t            sel_q
);

    localparam logic [IN_W-1:0] SPAN_Q = IN_W'(LOC_SPAN);

    logic [IN_W-1:0]  scaled [N_RNG];
    logic [N_RNG-1:0] fits;
    sel_t             nxt;

    // One scaled copy and one fit test per range
    for (genvar g = 0; g < N_RNG; g++) begin : g_rng
        assign scaled[g] = in_q >> (g * RNG_SHIFT);
        assign fits[g]   = (scaled[g] < SPAN_Q);
    end

    // Descending scan so the finest fitting range wins
    always_comb begin
        nxt.vld = in_valid;
        nxt.sat = 1'b1;
        nxt.rng = rng_t'(N_RNG - 1);
        nxt.loc = '1;
        for (int r = N_RNG - 1; r >= 0; r--) begin
            if (fits[r]) begin
                nxt.sat = 1'b0;
                nxt.rng = rng_t'(r);
                nxt.loc = scaled[r][LOC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= nxt;
    end

endmodule

// File: rtl/fq_seg_quant.sv
module fq_seg_quant
    import fq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel_q,
    output qnt_t qnt_q
);

    logic [N_SEG-1:0] reached;
    seg_t             seg;
    loc_t             offs;
    qnt_t             nxt;

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        assign reached[g] = (sel_q.loc >= seg_lo(seg_t'(g)));
    end

    // Highest segment whose lower edge has been reached
    always_comb begin
        seg = '0;
        for (int s = 0; s < N_SEG; s++) begin
            if (reached[s]) seg = seg_t'(s);
        end
    end

    assign offs = sel_q.loc - seg_lo(seg);

    always_comb begin
        nxt.vld = sel_q.vld;
        nxt.rng = sel_q.rng;
        if (sel_q.sat) begin
            nxt.seg  = seg_t'(N_SEG - 1);
            nxt.mant = '1;
        end else begin
            // bin width in local units is 2^segment
            nxt.seg  = seg;
            nxt.mant = seg_base(seg) + mant_t'(offs >> seg);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) qnt_q <= '0;
        else     qnt_q <= nxt;
    end

endmodule

// File: rtl/fq_recon.sv
module fq_recon
    import fq_pkg::*;
#(
    parameter int IN_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  qnt_t              qnt_q,
    output logic              out_valid,
    output logic [RNG_W-1:0]  out_range,
    output logic [MANT_W-1:0] out_mant,
    output logic [IN_W-1:0]   out_recon
);

    loc_t            lo_loc;
    logic [IN_W-1:0] lo_lin;
    logic [IN_W-1:0] wid_lin;
    logic [IN_W-1:0] centre;

    assign lo_loc  = seg_lo(qnt_q.seg)
                   + (loc_t'(qnt_q.mant - seg_base(qnt_q.seg)) << qnt_q.seg);
    assign lo_lin  = IN_W'(lo_loc) << (qnt_q.rng * RNG_SHIFT);
    assign wid_lin = IN_W'(1) << (qnt_q.seg + qnt_q.rng * RNG_SHIFT);
    assign centre  = lo_lin + (wid_lin >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_range <= '0;
            out_mant  <= '0;
            out_recon <= '0;
        end else begin
            out_valid <= qnt_q.vld;
            out_range <= qnt_q.rng;
            out_mant  <= qnt_q.mant;
            out_recon <= centre;
        end
    end

endmodule

// File: rtl/fq_encoder.sv
module fq_encoder
    import fq_pkg::*;
#(
    parameter int IN_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_q,
    output logic              out_valid,
    output logic [RNG_W-1:0]  out_range,
    output logic [MANT_W-1:0] out_mant,
    output logic [IN_W-1:0]   out_recon
);

    sel_t sel_q;
    qnt_t qnt_q;

    fq_range_sel #(.IN_W(IN_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_q     (in_q),
        .sel_q    (sel_q)
    );

    fq_seg_quant u_quant (
        .clk   (clk),
        .rst   (rst),
        .sel_q (sel_q),
        .qnt_q (qnt_q)
    );

    fq_recon #(.IN_W(IN_W)) u_recon (
        .clk       (clk),
        .rst       (rst),
        .qnt_q     (qnt_q),
        .out_valid (out_valid),
        .out_range (out_range),
        .out_mant  (out_mant),
        .out_recon (out_recon)
    );

endmodule

// File: rtl/fq_encoder_chk.sv
module fq_encoder_chk #(
    parameter int IN_W = 17
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [IN_W-1:0] in_q,
    input logic            out_valid,
    input logic [1:0]      out_range,
    input logic [5:0]      out_mant,
    input logic [IN_W-1:0] out_recon
);

    localparam logic [IN_W-1:0] LIM0  = IN_W'(192);
    localparam logic [IN_W-1:0] SAT_Q = IN_W'(192 << 9);

    logic [IN_W-1:0] q_d1, q_d2, q_d3;
    logic [1:0]      age;
    logic [IN_W+3:0] bin_w;
    logic [IN_W+3:0] err2;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
        q_d1 <= in_q;
        q_d2 <= q_d1;
        q_d3 <= q_d2;
    end

    always_comb begin
        if (out_mant < 6'd16)      bin_w = (IN_W+4)'(1);
        else if (out_mant < 6'd40) bin_w = (IN_W+4)'(2);
        else if (out_mant < 6'd56) bin_w = (IN_W+4)'(4);
        else                       bin_w = (IN_W+4)'(8);
        bin_w = bin_w << (out_range * 3);
        if (q_d3 >= out_recon) err2 = (IN_W+4)'(q_d3 - out_recon) << 1;
        else                   err2 = (IN_W+4)'(out_recon - q_d3) << 1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_range_fine_R2: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid && q_d3 < LIM0) |-> (out_range == 2'd0));

    assert_range_coarse_R2: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid && q_d3 >= LIM0) |-> (out_range != 2'd0));

    assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid && q_d3 >= SAT_Q)
        |-> (out_range == 2'd3 && out_mant == 6'd63));

    assert_unit_bins_R4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid && q_d3 < IN_W'(16))
        |-> (out_mant == q_d3[5:0]));

    assert_half_bin_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid && q_d3 < SAT_Q) |-> (err2 <= bin_w));

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind fq_encoder fq_encoder_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_range (out_range),
    .out_mant  (out_mant),
    .out_recon (out_recon)
);

// File: tb/fq_encoder_tb.sv
module fq_encoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 17;
    localparam int SAT        = 192 * 512;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_q = '0;
    logic            out_valid;
    logic [1:0]      out_range;
    logic [5:0]      out_mant;
    logic [IN_W-1:0] out_recon;

    int n_checks = 0;
    int n_fail   = 0;
    bit pv [3];
    int pq [3];

    fq_encoder #(.IN_W(IN_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_range (out_range),
        .out_mant  (out_mant),
        .out_recon (out_recon)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Lower local edge of mantissa bin k (k = 64 gives the span end)
    function automatic int edge_of(int k);
        if (k < 16) return k;
        if (k < 40) return 16 + (k - 16) * 2;
        if (k < 56) return 64 + (k - 40) * 4;
        if (k < 64) return 128 + (k - 56) * 8;
        return 192;
    endfunction

    task automatic model(input int q, output int r, output int m, output int rec);
        int loc;
        int w;
        if (q >= SAT) begin
            r = 3;
            m = 63;
        end else begin
            r = 0;
            while ((q >> (3 * r)) >= 192) r++;
            loc = q >> (3 * r);
            m = 0;
            for (int k = 0; k < 64; k++) if (edge_of(k) <= loc) m = k;
        end
        w   = edge_of(m + 1) - edge_of(m);
        rec = (edge_of(m) << (3 * r)) + ((w << (3 * r)) >> 1);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input string what, input int act, input int lim);
        n_checks++;
        if (act > lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected <= %0d", req, what, act, lim);
        end
    endtask

    // Compare the outputs with the sample applied three steps earlier
    task automatic check_slot(input string vreq);
        int r, m, rec, w, lo, err;
        if (pv[2]) begin
            chk(vreq, "out_valid", int'(out_valid), 1);
            model(pq[2], r, m, rec);
            chk(pq[2] >= SAT ? "R3" : "R2", "range", int'(out_range), r);
            chk(pq[2] >= SAT ? "R3" : "R4", "mantissa", int'(out_mant), m);
            chk("R5", "recon", int'(out_recon), rec);
            lo = edge_of(int'(out_mant));
            w  = edge_of(int'(out_mant) + 1) - lo;
            if (pq[2] < SAT) begin
                err = pq[2] - int'(out_recon);
                if (err < 0) err = -err;
                chk_le("R6", "2*|error|", 2 * err, w << (3 * int'(out_range)));
            end
            if (out_range != 2'd0) begin
                chk_le("R8", "12*width vs lo", 12 * w, lo);
                chk_le("R8", "lo vs 32*width", lo, 32 * w);
            end
        end else begin
            chk(vreq, "out_valid idle", int'(out_valid), 0);
        end
    endtask

    task automatic step(input bit v, input int q, input string vreq);
        check_slot(vreq);
        pv[2] = pv[1]; pq[2] = pq[1];
        pv[1] = pv[0]; pq[1] = pq[0];
        pv[0] = v;     pq[0] = q;
        in_valid = v;
        in_q     = IN_W'(q);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flush(input string vreq);
        repeat (3) step(1'b0, 0, vreq);
    endtask

    task automatic apply_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pv[i] = 1'b0;
            pq[i] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R7", "out_valid after reset", int'(out_valid), 0);
        chk("R7", "out_range after reset", int'(out_range), 0);
        chk("R7", "out_mant after reset", int'(out_mant), 0);
        chk("R7", "out_recon after reset", int'(out_recon), 0);
        rst = 1'b0;
    endtask

    task automatic t_unit_bins();
        for (int q = 0; q < 24; q++) step(1'b1, q, "R1");
        flush("R1");
    endtask

    task automatic t_boundaries();
        int pts [20] = '{15, 16, 17, 63, 64, 65, 127, 128, 129, 191,
                         192, 1535, 1536, 1537, 12287, 12288, 12289, 98303, 517, 4095};
        for (int i = 0; i < 20; i++) step(1'b1, pts[i], "R9");
        flush("R1");
    endtask

    task automatic t_saturation();
        step(1'b1, SAT, "R1");
        step(1'b1, SAT + 1, "R1");
        step(1'b1, 110000, "R1");
        step(1'b1, (1 << IN_W) - 1, "R1");
        flush("R1");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 16; i++) step(i % 3 != 1, 300 + i * 97, "R1");
        flush("R1");
    endtask

    task automatic t_mid_reset();
        step(1'b1, 5000, "R9");
        step(1'b1, 60000, "R9");
        step(1'b1, 70, "R9");
        apply_reset();
        flush("R7");
    endtask

    task automatic t_sweep();
        int unsigned s = 32'h1234_5678;
        int lims [4] = '{200, 1600, 12300, 110000};
        for (int i = 0; i < 2000; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            step(1'b1, int'((s >> 8) % lims[i % 4]), "R9");
        end
        flush("R1");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        apply_reset();
        t_unit_bins();
        t_boundaries();
        t_saturation();
        t_gaps();
        t_mid_reset();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule